// File: doc/BRIEF.md
# Fractional Clock Output Generator

This block produces a general-purpose output clock from one of several input clocks. A register port on the bus clock holds a control word and a divisor word. The selected source clock drives a divider. Its period is an integer number of source cycles plus an 8-bit fraction. The fraction is realised by lengthening single periods by one source cycle, so the average period comes out right over many periods.

The output starts and stops only at period boundaries, so it never makes a short pulse. The divisor can be rewritten while the output runs, and the new value is picked up at the next period start. A separate kill bit forces the output low at once, with no source edge needed. For odd integer divisors, an optional correction uses a half-cycle extension to give a 50 % high time. A start delay of 0 to 3 source cycles can be set while the generator is stopped. A read-only status word always reads 1, because there is no glitch-free source switch.

Top module: `fracclk_gen`

## Requirements
- R1: After reset the control word (address 0) reads 0, the divisor word (address 1) reads 0x00000100 (integer 1, fraction 0) and clk_out is low.
- R2: The divisor word holds the integer N in bits 23:8 and the fraction F in bits 7:0; bits 31:24 read 0. With F=0 and N≥2, each output period lasts N selected-source cycles, and the output is high for the first floor(N/2) of them.
- R3: An integer field of 0 divides by 65536, giving a high phase of 32768 source cycles.
- R4: With N=1 and F=0, clk_out copies the selected source clock, with one high half per source cycle.
- R5: Every period lasts N or N+1 cycles. A period gets the extra cycle when adding F to an 8-bit accumulator overflows. Any 256 consecutive periods therefore total 256·N+F cycles (for F=128, every two consecutive periods total 2N+1; for F=64, every four total 4N+1).
- R6: Control bit 6 turns on duty correction. With F=0 and odd N≥3, it makes the high time N source half-cycles. With F≠0 it has no effect.
- R7: A divisor written while running takes effect at the next period start. Every period has either the old length or the new length, never a mix.
- R8: Control bit 4 enables the output. Clearing it lets the current period finish, so every high pulse has full length, and the output then stays low.
- R9: Control bit 5 (kill) drives clk_out low at once, with no source edge needed, and holds it low while set. Clearing kill while enable is set restarts the output.
- R10: Control bits 9:8 set a start delay of that many extra source cycles. This field is written only when enable is currently clear; otherwise it keeps its previous value.
- R11: Control bits 3:0 select the source. Codes 0–10 select src_clk[code]. Codes 11–15 select no clock, so the output stays low.
- R12: Address 2 always reads 0x00000001 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 2 | Word address: 0 control, 1 divisor, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| src_clk | input | 11 | Candidate source clocks |
| clk_out | output | 1 | Generated output clock |

## Verification
The bench samples clk_out in the middle of every half-cycle of the selected source and derives period and high-time lengths from those samples. The stimulus covers:
- Even and odd integers with correction off and on, which separates floor-based high times from half-cycle-extended ones.
- Divide by one and divide by 65536, which exercise the two ends of the counter.
- Fractions 128 and 64, where only window sums of periods (pairs and fours) expose a wrong accumulator.
- Divisor writes and disables issued at random points inside a period, which show whether a period mixes old and new lengths or ends in a runt.
- A second source and an unused select code, which show that the mux really follows the select field.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;
    localparam int SEL_W  = 4;
    localparam int FRAC_W = 8;

    typedef struct packed {
        logic [1:0]       phase;
        logic             dc50;
        logic             kill;
        logic             enable;
        logic [SEL_W-1:0] src;
    } ctrl_t;
endpackage

// File: rtl/fracclk_regs.sv
module fracclk_regs
    import fracclk_pkg::*;
#(
    parameter int INT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output ctrl_t             ctrl,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac
);
    localparam int PAD_W = 32 - 8 - INT_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [INT_W-1:0]  dint;
        logic [FRAC_W-1:0] dfrac;
    } reg_state_t;

    reg_state_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                2'd0: begin
                    d.ctrl.src    = wdata[SEL_W-1:0];
                    d.ctrl.enable = wdata[4];
                    d.ctrl.kill   = wdata[5];
                    d.ctrl.dc50   = wdata[6];
                    if (!q.ctrl.enable) d.ctrl.phase = wdata[9:8];
                end
                2'd1: begin
                    d.dint  = wdata[8 +: INT_W];
                    d.dfrac = wdata[FRAC_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.dint <= INT_W'(1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            2'd0:    rdata = {22'd0, q.ctrl.phase, 1'b0, q.ctrl.dc50, q.ctrl.kill,
                              q.ctrl.enable, q.ctrl.src};
            2'd1:    rdata = {{PAD_W{1'b0}}, q.dint, q.dfrac};
            2'd2:    rdata = 32'd1;
            default: rdata = 32'd0;
        endcase
    end

    assign ctrl     = q.ctrl;
    assign div_int  = q.dint;
    assign div_frac = q.dfrac;

    // R10: start delay is frozen while the output is enabled
    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.ctrl.enable |=> $stable(q.ctrl.phase));
endmodule

// File: rtl/fracclk_srcmux.sv
module fracclk_srcmux
    import fracclk_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_sel
);
    always_comb begin
        clk_sel = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) clk_sel = src_clk[i];
        end
    end
endmodule

// File: rtl/fracclk_divider.sv
module fracclk_divider
    import fracclk_pkg::*;
#(
    parameter int INT_W = 16
) (
    input  logic              div_clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              enable,
    input  logic [1:0]        phase,
    input  logic              dc50,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              clk_out
);
    localparam int PER_W = INT_W + 1;

    typedef struct packed {
        logic              en_s1;
        logic              en_s2;
        logic [2:0]        pd;
        logic              running;
        logic [PER_W-1:0]  cnt;
        logic [PER_W-1:0]  period;
        logic [FRAC_W-1:0] acc;
        logic              hi;
        logic              dc_odd;
        logic              unity;
    } div_state_t;

    div_state_t s_q, s_d;
    logic arst_n, hi_n_q, gate_n_q, en_dly, at_end;
    logic [PER_W-1:0]  int_eff, per_new;
    logic [FRAC_W:0]   acc_sum;

    assign arst_n = rst_n & ~kill;

    always_comb begin
        int_eff = (div_int == '0) ? {1'b1, {INT_W{1'b0}}} : {1'b0, div_int};
        acc_sum = {1'b0, s_q.acc} + {1'b0, div_frac};
        per_new = int_eff + {{INT_W{1'b0}}, acc_sum[FRAC_W]};
        at_end  = (s_q.cnt == s_q.period - PER_W'(1));
        case (phase)
            2'd0:    en_dly = s_q.en_s2;
            2'd1:    en_dly = s_q.pd[0];
            2'd2:    en_dly = s_q.pd[1];
            default: en_dly = s_q.pd[2];
        endcase

        s_d       = s_q;
        s_d.en_s1 = enable;
        s_d.en_s2 = s_q.en_s1;
        s_d.pd    = {s_q.pd[1:0], s_q.en_s2};

        if (en_dly && (!s_q.running || at_end)) begin
            s_d.running = 1'b1;
            s_d.cnt     = '0;
            s_d.period  = per_new;
            s_d.acc     = acc_sum[FRAC_W-1:0];
            s_d.dc_odd  = dc50 && (div_frac == '0) && int_eff[0] && (int_eff != PER_W'(1));
            s_d.unity   = (per_new == PER_W'(1));
        end else if (s_q.running && at_end) begin
            s_d.running = 1'b0;
            s_d.cnt     = '0;
            s_d.dc_odd  = 1'b0;
            s_d.unity   = 1'b0;
        end else if (s_q.running) begin
            s_d.cnt = s_q.cnt + PER_W'(1);
        end
        s_d.hi = s_d.running && (s_d.cnt < (s_d.period >> 1));
    end

    always_ff @(posedge div_clk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    always_ff @(negedge div_clk or negedge arst_n) begin
        if (!arst_n) begin
            hi_n_q   <= 1'b0;
            gate_n_q <= 1'b0;
        end else begin
            hi_n_q   <= s_q.hi;
            gate_n_q <= s_q.running && s_q.unity;
        end
    end

    assign clk_out = s_q.hi | (s_q.dc_odd & hi_n_q) | (div_clk & gate_n_q);

    // R2: the cycle counter stays inside the captured period
    assert_cnt_bound_R2: assert property (@(posedge div_clk) disable iff (!arst_n)
        s_q.running |-> (s_q.cnt < s_q.period));
    // R7: a period keeps its length until its last cycle
    assert_period_hold_R7: assert property (@(posedge div_clk) disable iff (!arst_n)
        (s_q.running && !at_end) |=> $stable(s_q.period));
    // R8: running only ends on a period boundary
    assert_stop_edge_R8: assert property (@(posedge div_clk) disable iff (!arst_n)
        $fell(s_q.running) |-> $past(at_end));
    // R4: in divide-by-one mode the counter path never raises the output
    assert_unity_no_hi_R4: assert property (@(posedge div_clk) disable iff (!arst_n)
        (s_q.running && s_q.unity) |-> !s_q.hi);
    // R6: half-cycle extension only on odd periods
    assert_odd_only_R6: assert property (@(posedge div_clk) disable iff (!arst_n)
        s_q.dc_odd |-> s_q.period[0]);
endmodule

// File: rtl/fracclk_gen.sv
module fracclk_gen
    import fracclk_pkg::*;
#(
    parameter int NUM_SRC = 11,
    parameter int INT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic               clk_out
);
    ctrl_t             ctrl;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              clk_sel;

    fracclk_regs #(.INT_W(INT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .ctrl     (ctrl),
        .div_int  (div_int),
        .div_frac (div_frac)
    );

    fracclk_srcmux #(.NUM_SRC(NUM_SRC)) u_mux (
        .src_clk (src_clk),
        .sel     (ctrl.src),
        .clk_sel (clk_sel)
    );

    fracclk_divider #(.INT_W(INT_W)) u_div (
        .div_clk  (clk_sel),
        .rst_n    (rst_n),
        .kill     (ctrl.kill),
        .enable   (ctrl.enable),
        .phase    (ctrl.phase),
        .dc50     (ctrl.dc50),
        .div_int  (div_int),
        .div_frac (div_frac),
        .clk_out  (clk_out)
    );
endmodule

// File: tb/fracclk_gen_bench.sv
`timescale 1ns/1ps
module fracclk_gen_bench;
    localparam int NUM_SRC = 11;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0, rdata;
    logic [NUM_SRC-1:0] src_clk;
    logic clk_out, ref_clk;
    int errors = 0, checks = 0, sel_tb = 0;
    int per_a[8], hi_a[8];

    always #2 clk = ~clk;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic sc = 1'b0;
        initial forever #(5.0 + g) sc = ~sc;
        assign src_clk[g] = sc;
    end

    always_comb ref_clk = src_clk[sel_tb];

    fracclk_gen u_fracclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_clk(src_clk), .clk_out(clk_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    function automatic logic [31:0] ctrl_w(int src, bit en, bit kl, bit dc, int ph);
        return {22'd0, ph[1:0], 1'b0, dc, kl, en, src[3:0]};
    endfunction

    function automatic logic [31:0] div_w(int n, int f);
        return {8'd0, n[15:0], f[7:0]};
    endfunction

    function automatic int exp_hi(int n, bit dc);
        if (n == 1) return 1;
        if (dc && (n % 2 == 1)) return n;
        return 2 * (n / 2);
    endfunction

    task automatic smp(output logic v);
        @(ref_clk); #2; v = clk_out;
    endtask

    // sync=1: first wait for a rising edge; sync=0: caller is just after one
    task automatic measure(input int n, input bit sync);
        logic v;
        int guard = 0;
        if (sync) begin
            do begin smp(v); guard++; end while (v && guard < 300000);
            do begin smp(v); guard++; end while (!v && guard < 300000);
        end
        for (int k = 0; k < n; k++) begin
            int pc = 1, hc = 1;
            logic prev = 1'b1;
            forever begin
                smp(v);
                if (!prev && v) break;
                pc++;
                if (v) hc++;
                prev = v;
                if (pc > 300000) break;
            end
            per_a[k] = pc;
            hi_a[k]  = hc;
        end
    endtask

    task automatic start_latency(input int ph, output int lat);
        logic [31:0] r;
        wr(2'd0, ctrl_w(0, 0, 0, 0, ph));
        repeat (100) @(negedge clk);
        rd(2'd0, r);
        check(r[9:8] == ph[1:0], "R10 phase written while disabled", r[9:8], ph);
        wr(2'd0, ctrl_w(0, 1, 0, 0, ph));
        lat = 0;
        do begin @(posedge ref_clk); #2; lat++; end while (!clk_out && lat < 1000);
        wr(2'd0, ctrl_w(0, 0, 0, 0, ph));
        repeat (100) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic v;
        int lat0, lat3, n_old, bad, run, runs, hc;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(2'd0, r); check(r == 32'd0, "R1 control reset", r, 0);
        rd(2'd1, r); check(r == 32'h100, "R1 divisor reset", r, 32'h100);
        bad = 0;
        for (int i = 0; i < 10; i++) begin smp(v); if (v) bad++; end
        check(bad == 0, "R1 output low after reset", bad, 0);
        // R12 status word
        rd(2'd2, r); check(r == 32'd1, "R12 status reads one", r, 1);
        wr(2'd2, 32'd0);
        rd(2'd2, r); check(r == 32'd1, "R12 status ignores write", r, 1);

        // R2 even divisor
        wr(2'd1, div_w(4, 0));
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        measure(3, 1);
        check(per_a[2] == 8, "R2 period N=4", per_a[2], 8);
        check(hi_a[2] == 4, "R2 high N=4", hi_a[2], 4);
        // R2 odd divisor without correction
        wr(2'd1, div_w(5, 0));
        measure(3, 1);
        check(per_a[2] == 10, "R2 period N=5", per_a[2], 10);
        check(hi_a[2] == 4, "R2 high N=5", hi_a[2], 4);
        // R6 correction on odd divisors
        wr(2'd0, ctrl_w(0, 1, 0, 1, 0));
        measure(3, 1);
        check(hi_a[2] == 5, "R6 corrected high N=5", hi_a[2], 5);
        wr(2'd1, div_w(7, 0));
        measure(3, 1);
        check(per_a[2] == 14, "R6 period N=7", per_a[2], 14);
        check(hi_a[2] == 7, "R6 corrected high N=7", hi_a[2], 7);

        // R4 divide by one
        wr(2'd1, div_w(1, 0));
        measure(4, 1);
        check(per_a[3] == 2 && hi_a[3] == 1, "R4 source passthrough period", per_a[3], 2);

        // R5 fraction 128 with correction requested (R6: no effect)
        wr(2'd1, div_w(3, 128));
        measure(8, 1);
        bad = 0;
        for (int k = 1; k < 7; k++) if (per_a[k] + per_a[k+1] != 14) bad++;
        check(bad == 0, "R5 pair sums F=128", bad, 0);
        bad = 0;
        for (int k = 1; k < 8; k++)
            if (!((per_a[k] == 6 && hi_a[k] == 2) || (per_a[k] == 8 && hi_a[k] == 4))) bad++;
        check(bad == 0, "R6 no correction with fraction", bad, 0);
        // R5 fraction 64
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        wr(2'd1, div_w(2, 64));
        measure(8, 1);
        bad = 0;
        for (int k = 1; k < 5; k++)
            if (per_a[k] + per_a[k+1] + per_a[k+2] + per_a[k+3] != 18) bad++;
        check(bad == 0, "R5 four-period sums F=64", bad, 0);

        // R7 divisor change inside a period
        wr(2'd1, div_w(4, 0));
        measure(2, 1);
        fork
            begin #(7 + $urandom % 30); wr(2'd1, div_w(6, 0)); end
        join_none
        measure(4, 0);
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            if (per_a[k] != 8 && per_a[k] != 12) bad++;
            if (k > 0 && per_a[k-1] == 12 && per_a[k] == 8) bad++;
        end
        check(bad == 0, "R7 no mixed period", bad, 0);
        check(per_a[3] == 12, "R7 new divisor in use", per_a[3], 12);

        // R8 clean stop at a random point
        measure(1, 1);
        fork
            begin #($urandom % 110); wr(2'd0, ctrl_w(0, 0, 0, 0, 0)); end
        join_none
        bad = 0; run = 1; runs = 0;
        for (int i = 0; i < 80; i++) begin
            smp(v);
            if (v) run++;
            else if (run > 0) begin
                runs++;
                if (run != 6) bad++;
                run = 0;
            end
        end
        check(bad == 0 && runs >= 1, "R8 only full pulses before stop", bad, 0);
        check(v == 1'b0 && run == 0, "R8 output low after stop", v, 0);

        // R10 phase ignored while enabled, then start delay
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        wr(2'd0, ctrl_w(0, 1, 0, 0, 3));
        rd(2'd0, r);
        check(r[9:8] == 2'd0, "R10 phase write ignored while enabled", r[9:8], 0);
        wr(2'd0, ctrl_w(0, 0, 0, 0, 0));
        repeat (100) @(negedge clk);
        start_latency(0, lat0);
        start_latency(3, lat3);
        check(lat3 - lat0 >= 2 && lat3 - lat0 <= 4, "R10 start delay of three", lat3 - lat0, 3);

        // R9 kill
        wr(2'd1, div_w(8, 0));
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        do smp(v); while (!v);
        wr(2'd0, ctrl_w(0, 1, 1, 0, 0));
        check(clk_out == 1'b0, "R9 immediate kill", clk_out, 0);
        bad = 0;
        for (int i = 0; i < 30; i++) begin smp(v); if (v) bad++; end
        check(bad == 0, "R9 held low while killed", bad, 0);
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        measure(2, 1);
        check(per_a[1] == 16 && hi_a[1] == 8, "R9 restart after kill", per_a[1], 16);

        // R11 source select
        wr(2'd1, div_w(3, 0));
        wr(2'd0, ctrl_w(3, 1, 0, 0, 0));
        sel_tb = 3;
        measure(3, 1);
        check(per_a[2] == 6 && hi_a[2] == 2, "R11 source 3 period", per_a[2], 6);
        wr(2'd0, ctrl_w(3, 0, 0, 0, 0));
        repeat (300) @(negedge clk);
        wr(2'd0, ctrl_w(12, 1, 0, 0, 0));
        sel_tb = 0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin smp(v); if (v) bad++; end
        check(bad == 0, "R11 unused code gives no clock", bad, 0);
        wr(2'd0, ctrl_w(0, 0, 0, 0, 0));
        repeat (100) @(negedge clk);

        // R2/R6 random divisors, rewritten while running (R7)
        n_old = 3;
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        for (int it = 0; it < 6; it++) begin
            int n;
            bit dc;
            n  = 2 + int'($urandom % 8);
            dc = 1'($urandom % 2);
            wr(2'd1, div_w(n, 0));
            wr(2'd0, ctrl_w(0, 1, 0, dc, 0));
            measure(3, 1);
            for (int k = 1; k < 3; k++) begin
                check(per_a[k] == 2 * n, "R2 random period", per_a[k], 2 * n);
                check(hi_a[k] == exp_hi(n, dc), "R6 random high time", hi_a[k], exp_hi(n, dc));
            end
            n_old = n;
        end

        // R3 integer zero means 65536
        wr(2'd0, ctrl_w(0, 0, 0, 0, 0));
        repeat (200) @(negedge clk);
        wr(2'd1, div_w(0, 0));
        wr(2'd0, ctrl_w(0, 1, 0, 0, 0));
        do smp(v); while (!v);
        hc = 1;
        do begin smp(v); if (v) hc++; end while (v && hc < 70000);
        check(hc == 65536, "R3 high phase of divide by 65536", hc, 65536);
        wr(2'd0, ctrl_w(0, 1, 1, 0, 0));
        wr(2'd0, ctrl_w(0, 0, 0, 0, 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule